// File: doc/BRIEF.md
# Cascadable Quadrature Phase Counter

This block is one 16-bit up/down counter channel with three ways of advancing. In tick mode it counts up once per cycle in which a count-enable tick is high. In quadrature mode it decodes a two-phase encoder at 4x resolution. Each edge on either phase is one step, and the level of the other phase gives the direction. In cascade mode it counts up on a neighbouring channel's overflow pulse and down on its underflow pulse. Two channels chained this way act as a single 32-bit counter. The low channel supplies the low half and the cascaded channel supplies the high half.

Both phase pins and the two capture pins are asynchronous. Each passes through a two-flop synchronizer before it is used. A wrap from all-ones to zero while counting up raises a one-cycle overflow pulse. A wrap from zero to all-ones while counting down raises a one-cycle underflow pulse. A direction bit keeps the direction of the most recent step. The channel has two general registers. Each one is loaded by a write strobe and then acts either as a compare value or as a capture latch. A compare value raises a match flag while the count equals it. A capture latch stores the count on a chosen edge of its own pin.

There are no streaming interfaces. Every pin is a plain control or status signal, so no valid/ready back-pressure rules apply.

Top module: `quad_cascade_counter`

## Requirements
- R1: After reset the count is 0, the direction bit is 1 (up), the overflow and underflow pulses are 0, and both general registers hold 0.
- R2: With mode 2'b00 (tick) the count rises by one for every cycle in which tick is high. Phase pins and cascade inputs have no effect in this mode.
- R3: With mode 2'b01 (quadrature) every edge of either phase is one step. An edge on phase A counts up when the new A differs from B. An edge on phase B counts up when the new B equals A. Otherwise the step counts down.
- R4: In quadrature mode, a synchronized sample in which both phases changed at once produces no count.
- R5: The overflow pulse is high for exactly one cycle when the count wraps from 0xFFFF to 0x0000 on an up step. The underflow pulse is high for exactly one cycle when it wraps from 0x0000 to 0xFFFF on a down step.
- R6: The direction bit is 1 after an up step and 0 after a down step, and holds its value across cycles with no step.
- R7: With mode 2'b10 (cascade), casc_up counts up by one and casc_dn counts down by one. Both high in the same cycle gives no count, and tick and the phase pins have no effect. Feeding one channel's overflow and underflow into these inputs yields a coherent 32-bit count.
- R8: A write strobe gr_wr[i] loads gr_wdata into general register i on the next edge. When gr_capture[i] is 0 (compare), cmp_hit[i] is high exactly while the count equals that register.
- R9: When gr_capture[i] is 1, register i latches the count on an edge of cap_pin[i]. The edge is selected by cap_edge[2i+1:2i]: 2'b01 rising, 2'b10 falling, 2'b11 both, 2'b00 none. Edges that are not selected leave the register unchanged.
- R10: Mode 2'b11 (hold) produces no counting from any source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 00 tick, 01 quadrature, 10 cascade, 11 hold |
| tick | input | 1 | Count-enable tick for tick mode |
| ph_a | input | 1 | Encoder phase A, asynchronous |
| ph_b | input | 1 | Encoder phase B, asynchronous |
| casc_up | input | 1 | Neighbour overflow event (count up in cascade mode) |
| casc_dn | input | 1 | Neighbour underflow event (count down in cascade mode) |
| gr_wr | input | 2 | Per-register write strobe |
| gr_wdata | input | 16 | Write data shared by both general registers |
| gr_capture | input | 2 | Per-register role: 1 capture, 0 compare |
| cap_edge | input | 4 | Capture edge select, two bits per register |
| cap_pin | input | 2 | Capture trigger pins, asynchronous |
| count | output | 16 | Current count |
| dir_up | output | 1 | Direction of the most recent step (1 up) |
| ovf | output | 1 | One-cycle overflow pulse |
| udf | output | 1 | One-cycle underflow pulse |
| gr_q | output | 32 | General registers, register i at bits 16i+15:16i |
| cmp_hit | output | 2 | Compare match flags |

## Verification
Some properties are checked on every cycle by assertions:
- the count never moves by more than one step;
- a wrap pulse only accompanies the matching wrap of the count;
- the direction bit follows the step just taken;
- a simultaneous change of both phases never yields a step;
- a write or a selected capture edge lands its value in the register one edge later.

Other behaviour can only be shown by the bench scenarios, which drive stimulus and compare outputs against values computed independently:
- the full 4x decode sequence in both directions;
- the exact count after 65,536 ticks;
- the two-channel chain stepping together across zero;
- the ignored sources in each mode;
- capture edges that are not selected leaving the register unchanged.

// File: rtl/qcc_pkg.sv
package qcc_pkg;
  typedef enum logic [1:0] {
    MODE_TICK = 2'b00,
    MODE_QUAD = 2'b01,
    MODE_CASC = 2'b10,
    MODE_HOLD = 2'b11
  } cnt_mode_e;

  localparam logic [1:0] EDGE_NONE = 2'b00;
  localparam logic [1:0] EDGE_RISE = 2'b01;
  localparam logic [1:0] EDGE_FALL = 2'b10;
  localparam logic [1:0] EDGE_BOTH = 2'b11;
endpackage

// File: rtl/qcc_sync.sv
module qcc_sync #(
  parameter int BITS   = 4,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [BITS-1:0] d,
  output logic [BITS-1:0] q
);
  logic [BITS-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= d;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/qcc_decode.sv
module qcc_decode (
  input  logic clk,
  input  logic rst_n,
  input  logic a,
  input  logic b,
  output logic step,
  output logic up
);
  logic a_prev, b_prev;
  logic a_chg, b_chg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_prev <= 1'b0;
      b_prev <= 1'b0;
    end else begin
      a_prev <= a;
      b_prev <= b;
    end
  end

  assign a_chg = a ^ a_prev;
  assign b_chg = b ^ b_prev;

  // 4x decode: exactly one phase moved is a legal step
  always_comb begin
    step = a_chg ^ b_chg;
    if (a_chg) up = (a != b);
    else       up = (b == a);
  end

  // R4: a double change never becomes a step
  assert_no_double_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (a_chg && b_chg) |-> !step);
endmodule

// File: rtl/qcc_counter.sv
module qcc_counter #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  output logic [WIDTH-1:0] count,
  output logic             dir_up,
  output logic             ovf,
  output logic             udf
);
  localparam logic [WIDTH-1:0] CNT_MAX = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] CNT_ONE = WIDTH'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count  <= '0;
      dir_up <= 1'b1;
      ovf    <= 1'b0;
      udf    <= 1'b0;
    end else begin
      ovf <= 1'b0;
      udf <= 1'b0;
      if (inc && !dec) begin
        count  <= count + CNT_ONE;
        dir_up <= 1'b1;
        ovf    <= (count == CNT_MAX);
      end else if (dec && !inc) begin
        count  <= count - CNT_ONE;
        dir_up <= 1'b0;
        udf    <= (count == '0);
      end
    end
  end

  // R5: wrap pulses only with the matching wrap
  assert_ovf_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> (count == '0) && ($past(count) == CNT_MAX));
  assert_udf_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    udf |-> (count == CNT_MAX) && ($past(count) == '0));
  assert_pulse_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf && udf));
  // R6: direction bit tracks the step just taken
  assert_dir_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !dec) |=> dir_up);
  assert_dir_dn_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !inc) |=> !dir_up);
  // R2: count moves at most one step per cycle
  assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (count != $past(count)) |->
      ((count == $past(count) + CNT_ONE) || (count == $past(count) - CNT_ONE)));
endmodule

// File: rtl/qcc_genreg.sv
module qcc_genreg #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] count,
  input  logic             wr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             capture,
  input  logic [1:0]       edge_sel,
  input  logic             pin,
  output logic [WIDTH-1:0] value,
  output logic             hit
);
  logic pin_prev;
  logic rise, fall, trig;

  always_ff @(posedge clk) begin
    if (!rst_n) pin_prev <= 1'b0;
    else        pin_prev <= pin;
  end

  assign rise = pin & ~pin_prev;
  assign fall = ~pin & pin_prev;
  assign trig = capture && ((edge_sel[0] && rise) || (edge_sel[1] && fall));

  // a write takes priority over a capture in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n)    value <= '0;
    else if (wr)   value <= wdata;
    else if (trig) value <= count;
  end

  assign hit = !capture && (value == count);

  // R8: write lands one edge later
  assert_write_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (value == $past(wdata)));
  // R9: a selected edge latches the count
  assert_capture_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !wr) |=> (value == $past(count)));
  // R9: without write or trigger the register holds
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr && !trig) |=> $stable(value));
endmodule

// File: rtl/quad_cascade_counter.sv
module quad_cascade_counter
  import qcc_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int NUM_GR      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              mode,
  input  logic                    tick,
  input  logic                    ph_a,
  input  logic                    ph_b,
  input  logic                    casc_up,
  input  logic                    casc_dn,
  input  logic [NUM_GR-1:0]       gr_wr,
  input  logic [WIDTH-1:0]        gr_wdata,
  input  logic [NUM_GR-1:0]       gr_capture,
  input  logic [2*NUM_GR-1:0]     cap_edge,
  input  logic [NUM_GR-1:0]       cap_pin,
  output logic [WIDTH-1:0]        count,
  output logic                    dir_up,
  output logic                    ovf,
  output logic                    udf,
  output logic [NUM_GR*WIDTH-1:0] gr_q,
  output logic [NUM_GR-1:0]       cmp_hit
);
  localparam int SYNC_BITS = 2 + NUM_GR;

  cnt_mode_e             cmode;
  logic [SYNC_BITS-1:0]  sync_q;
  logic                  a_s, b_s;
  logic [NUM_GR-1:0]     cap_s;
  logic                  q_step, q_up;
  logic                  inc, dec;

  assign cmode = cnt_mode_e'(mode);

  qcc_sync #(.BITS(SYNC_BITS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({cap_pin, ph_b, ph_a}),
    .q     (sync_q)
  );

  assign a_s   = sync_q[0];
  assign b_s   = sync_q[1];
  assign cap_s = sync_q[SYNC_BITS-1:2];

  qcc_decode u_decode (
    .clk   (clk),
    .rst_n (rst_n),
    .a     (a_s),
    .b     (b_s),
    .step  (q_step),
    .up    (q_up)
  );

  always_comb begin
    inc = 1'b0;
    dec = 1'b0;
    unique case (cmode)
      MODE_TICK: inc = tick;
      MODE_QUAD: begin
        inc = q_step && q_up;
        dec = q_step && !q_up;
      end
      MODE_CASC: begin
        inc = casc_up && !casc_dn;
        dec = casc_dn && !casc_up;
      end
      MODE_HOLD: ;
    endcase
  end

  qcc_counter #(.WIDTH(WIDTH)) u_counter (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc    (inc),
    .dec    (dec),
    .count  (count),
    .dir_up (dir_up),
    .ovf    (ovf),
    .udf    (udf)
  );

  generate
    for (genvar i = 0; i < NUM_GR; i++) begin : g_gr
      qcc_genreg #(.WIDTH(WIDTH)) u_gr (
        .clk      (clk),
        .rst_n    (rst_n),
        .count    (count),
        .wr       (gr_wr[i]),
        .wdata    (gr_wdata),
        .capture  (gr_capture[i]),
        .edge_sel (cap_edge[2*i+1:2*i]),
        .pin      (cap_s[i]),
        .value    (gr_q[i*WIDTH +: WIDTH]),
        .hit      (cmp_hit[i])
      );
    end
  endgenerate

  // R10: hold mode never moves the count
  assert_hold_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmode == MODE_HOLD) |=> (count == $past(count)));
  // R7: cascade with both events asserted leaves the count alone
  assert_casc_cancel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmode == MODE_CASC && casc_up && casc_dn) |=> (count == $past(count)));
endmodule

// File: tb/quad_cascade_counter_bench.sv
`timescale 1ns/1ps
module quad_cascade_counter_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  mode;
  logic        tick, ph_a, ph_b, casc_up, casc_dn;
  logic [1:0]  gr_wr, gr_capture, cap_pin;
  logic [15:0] gr_wdata;
  logic [3:0]  cap_edge;
  logic [15:0] count, hi_count;
  logic        dir_up, ovf, udf, hi_dir, hi_ovf, hi_udf;
  logic [31:0] gr_q, hi_gr_q;
  logic [1:0]  cmp_hit, hi_hit;

  int n_chk = 0;
  int n_bad = 0;
  int ovf_n = 0;
  int udf_n = 0;

  always #2 clk = ~clk;

  quad_cascade_counter u_quad_cascade_counter (
    .clk(clk), .rst_n(rst_n), .mode(mode), .tick(tick), .ph_a(ph_a), .ph_b(ph_b),
    .casc_up(casc_up), .casc_dn(casc_dn), .gr_wr(gr_wr), .gr_wdata(gr_wdata),
    .gr_capture(gr_capture), .cap_edge(cap_edge), .cap_pin(cap_pin),
    .count(count), .dir_up(dir_up), .ovf(ovf), .udf(udf), .gr_q(gr_q), .cmp_hit(cmp_hit)
  );

  // upper half of a 32-bit chain, fed by the main channel's wrap pulses
  quad_cascade_counter u_hi (
    .clk(clk), .rst_n(rst_n), .mode(2'b10), .tick(1'b0), .ph_a(1'b0), .ph_b(1'b0),
    .casc_up(ovf), .casc_dn(udf), .gr_wr(2'b00), .gr_wdata(16'h0),
    .gr_capture(2'b00), .cap_edge(4'h0), .cap_pin(2'b00),
    .count(hi_count), .dir_up(hi_dir), .ovf(hi_ovf), .udf(hi_udf), .gr_q(hi_gr_q), .cmp_hit(hi_hit)
  );

  always @(negedge clk) begin
    if (rst_n && ovf) ovf_n++;
    if (rst_n && udf) udf_n++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; mode = 2'b00; tick = 1'b0; ph_a = 1'b0; ph_b = 1'b0;
    casc_up = 1'b0; casc_dn = 1'b0; gr_wr = 2'b00; gr_wdata = 16'h0;
    gr_capture = 2'b00; cap_edge = 4'h0; cap_pin = 2'b00;
    cyc(3);
    rst_n = 1'b1;
    ovf_n = 0; udf_n = 0;
    cyc(1);
  endtask

  task automatic ticks(input int n);
    tick = 1'b1; cyc(n); tick = 1'b0;
  endtask

  task automatic set_a(input logic v);
    ph_a = v; cyc(5);
  endtask

  task automatic set_b(input logic v);
    ph_b = v; cyc(5);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 count", count, 0);
    chk("R1 dir", dir_up, 1);
    chk("R1 ovf/udf", {ovf, udf}, 0);
    chk("R1 gr_q", gr_q, 0);
  endtask

  task automatic t_tick();
    do_reset();
    ticks(10);
    chk("R2 tick count", count, 10);
    ph_a = 1'b1; ph_b = 1'b1; casc_up = 1'b1; cyc(6);
    casc_up = 1'b0; casc_dn = 1'b1; cyc(3); casc_dn = 1'b0;
    chk("R2 phase/cascade ignored", count, 10);
  endtask

  task automatic t_quad();
    do_reset();
    mode = 2'b01;
    for (int k = 0; k < 2; k++) begin
      set_a(1); set_b(1); set_a(0); set_b(0);
    end
    chk("R3 forward 8 edges", count, 8);
    chk("R6 dir after up", dir_up, 1);
    set_b(1); set_a(1); set_b(0);
    chk("R3 reverse 3 edges", count, 5);
    chk("R6 dir after down", dir_up, 0);
    cyc(10);
    chk("R6 dir held", dir_up, 0);
  endtask

  task automatic t_illegal();
    do_reset();
    mode = 2'b01;
    ph_a = 1'b1; ph_b = 1'b1; cyc(6);
    chk("R4 double change no count", count, 0);
    set_a(0);
    chk("R4 decode resumes", count, 1);
  endtask

  task automatic t_wrap_quad();
    do_reset();
    mode = 2'b01;
    set_b(1);
    chk("R5 underflow count", count, 16'hFFFF);
    chk("R5 underflow one pulse", udf_n, 1);
    chk("R7 chain high after borrow", hi_count, 16'hFFFF);
    set_b(0);
    chk("R5 overflow count", count, 0);
    chk("R5 overflow one pulse", ovf_n, 1);
    chk("R7 chain high after carry", hi_count, 0);
  endtask

  task automatic t_wrap_tick();
    do_reset();
    ticks(65535);
    chk("R5 tick to max", count, 16'hFFFF);
    chk("R5 no early ovf", ovf_n, 0);
    ticks(1);
    cyc(2);
    chk("R5 tick wrap", count, 0);
    chk("R5 tick ovf pulse", ovf_n, 1);
    chk("R7 chain 32-bit value", {hi_count, count}, 32'h0001_0000);
  endtask

  task automatic t_cascade();
    do_reset();
    mode = 2'b10;
    for (int k = 0; k < 3; k++) begin
      casc_up = 1'b1; cyc(1); casc_up = 1'b0; cyc(1);
    end
    chk("R7 casc up x3", count, 3);
    casc_dn = 1'b1; cyc(1); casc_dn = 1'b0; cyc(1);
    chk("R7 casc down", count, 2);
    chk("R6 casc dir", dir_up, 0);
    casc_up = 1'b1; casc_dn = 1'b1; cyc(1); casc_up = 1'b0; casc_dn = 1'b0; cyc(1);
    chk("R7 both cancel", count, 2);
    ticks(3); set_a(1);
    chk("R7 tick/phase ignored", count, 2);
  endtask

  task automatic t_hold();
    do_reset();
    mode = 2'b11;
    ticks(4); set_a(1); set_b(1);
    casc_up = 1'b1; cyc(2); casc_up = 1'b0;
    chk("R10 hold no count", count, 0);
  endtask

  task automatic t_compare();
    do_reset();
    gr_wdata = 16'd5; gr_wr = 2'b01; cyc(1); gr_wr = 2'b00;
    chk("R8 write load", gr_q[15:0], 5);
    ticks(4);
    chk("R8 no hit at 4", cmp_hit[0], 0);
    ticks(1);
    chk("R8 hit at 5", cmp_hit[0], 1);
    ticks(1);
    chk("R8 hit cleared at 6", cmp_hit[0], 0);
  endtask

  task automatic t_capture();
    do_reset();
    gr_capture = 2'b10; cap_edge = 4'b0100;
    ticks(7);
    cap_pin[1] = 1'b1; cyc(5);
    chk("R9 rising capture", gr_q[31:16], 7);
    ticks(2);
    cap_pin[1] = 1'b0; cyc(5);
    chk("R9 falling ignored on rise select", gr_q[31:16], 7);
    cap_edge = 4'b1000;
    cap_pin[1] = 1'b1; cyc(5);
    chk("R9 rising ignored on fall select", gr_q[31:16], 7);
    ticks(1);
    cap_pin[1] = 1'b0; cyc(5);
    chk("R9 falling capture", gr_q[31:16], 10);
    chk("R8 capture reg gives no hit", cmp_hit[1], 0);
  endtask

  initial begin
    #(190000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    t_reset();
    t_tick();
    t_quad();
    t_illegal();
    t_wrap_quad();
    t_cascade();
    t_hold();
    t_compare();
    t_capture();
    t_wrap_tick();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule